// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block is a bus master. It turns single internal read and write requests into cycles on a 16-bit external bus where the address and the data share the same lines. Every cycle starts with an address phase. During that phase the block drives the address and raises an address-enable strobe, so that an external latch can capture the address. A data phase follows, with an active-low read or write strobe, active-low byte enables and one active-low select for each of four address windows. No ready or wait input exists. The timing fields of the window that was hit set the length of every phase, and nothing else does.

Each window is 128 KB. The window bases sit at 0x1000_0000, 0x2000_0000, 0x3000_0000 and 0x4000_0000. Each window has a control word, which holds an enable and a bus width, and a timing word. The timing word can lengthen the address phase, add an address-hold clock, add a read turnaround clock, add a trailing hold clock, and stretch the read and write strobes. A global enable gates all external traffic. A request that cannot run completes at once with an error flag and causes no activity on the bus.

Top module: `xbus_master`

## Requirements
- R1: A request whose bits [31:28] equal n+1 and whose bits [27:17] are zero hits window n. Only select ms_n[n] goes low, and it stays low and unchanged for every clock of that cycle.
- R2: A request completes with rsp_err=1 on the clock after it is accepted, and produces no select, strobe, address enable or bus drive, in any of these cases: the global enable is clear, the window is disabled, or the address lies in no window.
- R3: Configuration writes use these cfg_addr values. Address 0 holds the global enable in bit 0. Address 4+n holds window n's control word: bit 0 enables the window and bit 1 selects 16-bit width. Address 8+n holds window n's timing word. After reset the control words and the global enable are 0 and every timing word is 0x70FF.
- R4: The address phase lasts 1 + timing[14:12] clocks. In it, ae is high, ad_oe is high and ad_o carries the address.
- R5: When timing[10] is set, one clock follows the address phase in which the address is still driven and ae, rs_n and ws_n are all inactive.
- R6: On reads with timing[9] set, one clock with the bus released and both strobes high comes before the read strobe. Writes ignore this bit.
- R7: rs_n stays low for 2 + timing[3:0] clocks. ad_i is captured at the rising edge that ends the last of these clocks, and rsp_rdata returns it.
- R8: ws_n stays low for 2 + timing[7:4] clocks. During these clocks the write data is driven and the byte enables follow req_be (bit 1 is the high lane and bit 0 is the low lane; a 1 enables the lane).
- R9: When timing[8] is set, one clock follows the strobe with the select still low. A write keeps its data driven in that clock and a read keeps the bus released.
- R10: On a 16-bit read the byte enables are low for exactly one clock, the last clock of the read strobe.
- R11: In an 8-bit window (control bit 1 = 0), bhe_n and ble_n stay high. a16 carries address bit 16 and ad_o carries address bits [15:0]. Write data goes out as {8'h00, wdata[7:0]}, and read data comes back as {8'h00, ad_i[7:0]}.
- R12: In a 16-bit window the address phase drives address bits [16:1] and a16 stays low.
- R13: During a read the block does not drive the bus after the address phase (and after the hold clock, if one is set).
- R14: req_ready is high only while no cycle is running. rsp_valid is a pulse one clock long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word select |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 1 high lane |
| rsp_valid | output | 1 | Completion pulse |
| rsp_err | output | 1 | Request refused, no bus cycle |
| rsp_rdata | output | 16 | Read data |
| ad_o | output | 16 | Shared address/data lines, outgoing value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_i | input | 16 | Shared lines, incoming value |
| a16 | output | 1 | Extra address line for 8-bit windows |
| ae | output | 1 | Address enable for the external latch |
| rs_n | output | 1 | Read strobe, active low |
| ws_n | output | 1 | Write strobe, active low |
| ms_n | output | 4 | Window selects, active low |
| bhe_n | output | 1 | High byte enable, active low |
| ble_n | output | 1 | Low byte enable, active low |

## Verification
The assertions hold on every clock for the rules that do not depend on counting. At most one select is low, and it stays unchanged through a cycle. The two strobes are never low together. The bus is never driven while the read strobe is low. A read's byte enables are followed at once by the strobe's rising edge. An 8-bit window never asserts a byte enable. A refused request leaves the bus quiet. The phase lengths depend on each window's timing fields, so only the directed scenarios can show them: they count the clocks of each phase, check the address and data seen on the lines, and drive read data only in the final strobe clock to prove where the capture happens.

// File: rtl/xbus_pkg.sv
// Shared types for the multiplexed external bus controller.
// Assumes a 16-bit shared address/data bus with two byte lanes.
package xbus_pkg;

    localparam int BUS_W = 16;

    // Phases of one external cycle.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_TURN,
        ST_STRB,
        ST_TAIL
    } xb_state_e;

    // Decoded per-window timing fields.
    typedef struct packed {
        logic [2:0] addr_ext;
        logic       addr_hold;
        logic       rd_turn;
        logic       tail_hold;
        logic [3:0] wr_stretch;
        logic [3:0] rd_stretch;
    } xb_timing_t;

endpackage

// File: rtl/xbus_cfg.sv
// Configuration storage: global enable plus control and timing per window.
// Word map: 0 = global, NUM_WIN+n = control of window n, 2*NUM_WIN+n = timing.
// Assumes writes are single-cycle strobes; there is no readback.
module xbus_cfg
    import xbus_pkg::*;
#(
    parameter int          NUM_WIN = 4,
    parameter logic [15:0] TIM_RST = 16'h70FF,
    parameter int          CFG_AW  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [15:0]                  cfg_wdata,
    output logic                         glob_en,
    output logic [NUM_WIN-1:0]           win_en,
    output logic [NUM_WIN-1:0]           win_wide,
    output xb_timing_t [NUM_WIN-1:0]     win_tim
);

    localparam int CTRL_BASE = NUM_WIN;
    localparam int TIM_BASE  = 2 * NUM_WIN;

    // Field slices of an incoming timing word.
    xb_timing_t tim_wr;
    xb_timing_t tim_rst_val;
    logic       unused_tim_bits;

    assign tim_wr          = '{addr_ext: cfg_wdata[14:12], addr_hold: cfg_wdata[10],
                               rd_turn: cfg_wdata[9], tail_hold: cfg_wdata[8],
                               wr_stretch: cfg_wdata[7:4], rd_stretch: cfg_wdata[3:0]};
    assign tim_rst_val     = '{addr_ext: TIM_RST[14:12], addr_hold: TIM_RST[10],
                               rd_turn: TIM_RST[9], tail_hold: TIM_RST[8],
                               wr_stretch: TIM_RST[7:4], rd_stretch: TIM_RST[3:0]};
    assign unused_tim_bits = ^{cfg_wdata[15], cfg_wdata[11], TIM_RST[15], TIM_RST[11]};

    // Global enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            glob_en <= 1'b0;
        else if (cfg_we && cfg_addr == '0)
            glob_en <= cfg_wdata[0];
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic       en_q;
        logic       wide_q;
        xb_timing_t tim_q;

        // Control and timing words of this window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q   <= 1'b0;
                wide_q <= 1'b0;
                tim_q  <= tim_rst_val;
            end else if (cfg_we) begin
                if (cfg_addr == CFG_AW'(CTRL_BASE + w)) begin
                    en_q   <= cfg_wdata[0];
                    wide_q <= cfg_wdata[1];
                end
                if (cfg_addr == CFG_AW'(TIM_BASE + w))
                    tim_q <= tim_wr;
            end
        end

        assign win_en[w]   = en_q;
        assign win_wide[w] = wide_q;
        assign win_tim[w]  = tim_q;

        // R3: the timing word holds its reset value in the first clock after reset.
        p_tim_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (tim_q == tim_rst_val))
            else $error("window timing not at reset value");
    end

endmodule

// File: rtl/xbus_win_dec.sv
// Window decoder: matches the upper address bits against the window bases.
// Window n starts at (n+1) << SEL_LSB and spans 2**WIN_BITS bytes.
// Assumes the request address is stable while it is being accepted.
module xbus_win_dec #(
    parameter int NUM_WIN  = 4,
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 17,
    parameter int SEL_LSB  = 28,
    parameter int IDX_W    = 2
) (
    input  logic [ADDR_W-1:WIN_BITS] addr_hi,
    input  logic                     glob_en,
    input  logic [NUM_WIN-1:0]       win_en,
    output logic [NUM_WIN-1:0]       hit,
    output logic [IDX_W-1:0]         hit_idx,
    output logic                     hit_ok
);

    localparam int SEL_W = ADDR_W - SEL_LSB;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
        assign hit[w] = (addr_hi[ADDR_W-1:SEL_LSB] == SEL_W'(w + 1)) &&
                        (addr_hi[SEL_LSB-1:WIN_BITS] == '0);
    end

    // Encode the matching window number.
    always_comb begin
        hit_idx = '0;
        for (int w = 0; w < NUM_WIN; w++)
            if (hit[w]) hit_idx = IDX_W'(w);
    end

    assign hit_ok = glob_en && |(hit & win_en);

endmodule

// File: rtl/xbus_seq.sv
// Cycle sequencer: runs one external cycle per accepted request through the
// phases address, hold, turnaround, strobe and tail, with the lengths taken
// from the hit window's timing word. It also owns the bus drive enable.
// Assumes the request fields stay valid during the cycle in which it is accepted.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [16:0]              req_addr_lo,
    input  logic [BUS_W-1:0]         req_wdata,
    input  logic [1:0]               req_be,
    input  logic                     dec_ok,
    input  logic [NUM_WIN-1:0]       dec_hit,
    input  logic [IDX_W-1:0]         dec_idx,
    input  logic [NUM_WIN-1:0]       win_wide,
    input  xb_timing_t [NUM_WIN-1:0] win_tim,
    output logic                     rsp_valid,
    output logic                     rsp_err,
    output logic [BUS_W-1:0]         rsp_rdata,
    output logic [BUS_W-1:0]         ad_o,
    output logic                     ad_oe,
    input  logic [BUS_W-1:0]         ad_i,
    output logic                     a16,
    output logic                     ae,
    output logic                     rs_n,
    output logic                     ws_n,
    output logic [NUM_WIN-1:0]       ms_n,
    output logic                     bhe_n,
    output logic                     ble_n
);

    localparam int CNT_W = 5;

    xb_state_e          state_q, nxt_st;
    logic [CNT_W-1:0]   cnt_q, nxt_cnt;
    logic               fin;
    logic               wr_q, wide_q;
    logic [16:0]        addr_q;
    logic [BUS_W-1:0]   wdata_q;
    logic [1:0]         be_q;
    logic [NUM_WIN-1:0] sel_q;
    xb_timing_t         tim_q;
    logic               rsp_valid_q, rsp_err_q;
    logic [BUS_W-1:0]   rdata_q;

    logic               active, addr_phase, be_on;
    xb_state_e          data_st;
    logic [CNT_W-1:0]   data_cnt, strb_len;

    // Strobe length minus one, and the first phase after the address part.
    always_comb begin
        strb_len = CNT_W'(1) + CNT_W'(wr_q ? tim_q.wr_stretch : tim_q.rd_stretch);
        data_st  = (!wr_q && tim_q.rd_turn) ? ST_TURN : ST_STRB;
        data_cnt = (data_st == ST_TURN) ? '0 : strb_len;
    end

    // Choose the phase that follows the current one.
    always_comb begin
        nxt_st  = state_q;
        nxt_cnt = cnt_q;
        fin     = 1'b0;
        if (state_q != ST_IDLE) begin
            if (cnt_q != '0) begin
                nxt_cnt = cnt_q - CNT_W'(1);
            end else begin
                case (state_q)
                    ST_ADDR: begin
                        if (tim_q.addr_hold) begin
                            nxt_st  = ST_HOLD;
                            nxt_cnt = '0;
                        end else begin
                            nxt_st  = data_st;
                            nxt_cnt = data_cnt;
                        end
                    end
                    ST_HOLD: begin
                        nxt_st  = data_st;
                        nxt_cnt = data_cnt;
                    end
                    ST_TURN: begin
                        nxt_st  = ST_STRB;
                        nxt_cnt = strb_len;
                    end
                    ST_STRB: begin
                        if (tim_q.tail_hold) begin
                            nxt_st  = ST_TAIL;
                            nxt_cnt = '0;
                        end else begin
                            nxt_st = ST_IDLE;
                            fin    = 1'b1;
                        end
                    end
                    ST_TAIL: begin
                        nxt_st = ST_IDLE;
                        fin    = 1'b1;
                    end
                    default: nxt_st = ST_IDLE;
                endcase
            end
        end
    end

    // Accept requests, step the phases, and produce responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            wr_q        <= 1'b0;
            wide_q      <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
            be_q        <= '0;
            sel_q       <= '0;
            tim_q       <= '0;
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rdata_q     <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (req_valid) begin
                    rdata_q <= '0;
                    if (dec_ok) begin
                        state_q <= ST_ADDR;
                        cnt_q   <= CNT_W'(win_tim[dec_idx].addr_ext);
                        tim_q   <= win_tim[dec_idx];
                        wide_q  <= win_wide[dec_idx];
                        sel_q   <= dec_hit;
                        wr_q    <= req_write;
                        addr_q  <= req_addr_lo;
                        wdata_q <= req_wdata;
                        be_q    <= req_be;
                    end else begin
                        rsp_valid_q <= 1'b1;
                        rsp_err_q   <= 1'b1;
                    end
                end
            end else begin
                state_q <= nxt_st;
                cnt_q   <= nxt_cnt;
                if (fin) begin
                    rsp_valid_q <= 1'b1;
                    rsp_err_q   <= 1'b0;
                end
                if (state_q == ST_STRB && cnt_q == '0 && !wr_q)
                    rdata_q <= wide_q ? ad_i : {8'h00, ad_i[7:0]};
            end
        end
    end

    // Pin values decoded from the phase register and the latched request.
    always_comb begin
        active     = (state_q != ST_IDLE);
        addr_phase = (state_q == ST_ADDR) || (state_q == ST_HOLD);
        be_on      = wide_q && (state_q == ST_STRB) && (wr_q || cnt_q == '0);
        req_ready  = !active;
        ms_n       = active ? ~sel_q : '1;
        ae         = (state_q == ST_ADDR);
        ad_oe      = addr_phase || (wr_q && (state_q == ST_STRB || state_q == ST_TAIL));
        if (addr_phase)
            ad_o = wide_q ? addr_q[16:1] : addr_q[15:0];
        else
            ad_o = wide_q ? wdata_q : {8'h00, wdata_q[7:0]};
        a16        = active && !wide_q && addr_q[16];
        rs_n       = !((state_q == ST_STRB) && !wr_q);
        ws_n       = !((state_q == ST_STRB) && wr_q);
        bhe_n      = !(be_on && be_q[1]);
        ble_n      = !(be_on && be_q[0]);
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_err   = rsp_err_q;
    assign rsp_rdata = rdata_q;

    // R1: at most one select low, unchanged through a running cycle.
    p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ms_n)) else $error("more than one select low");
    p_select_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> $stable(ms_n)) else $error("select moved mid-cycle");
    // R2: a refused request leaves the bus quiet.
    p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ((&ms_n) && !ad_oe && rs_n && ws_n && !ae))
        else $error("bus active on refused request");
    // R4: the address enable only appears with the address driven and a select low.
    p_ae_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ae |-> (ad_oe && !(&ms_n))) else $error("ae without driven address");
    // R8: the strobes never overlap.
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rs_n && !ws_n)) else $error("read and write strobes together");
    // R13: the bus is released while the read strobe is low.
    p_read_release_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_n |-> !ad_oe) else $error("bus driven during read strobe");
    // R10: read byte enables are followed at once by the strobe rising.
    p_rd_be_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rs_n && (!bhe_n || !ble_n)) |=> rs_n) else $error("read enables not in last clock");
    // R11: an 8-bit window never asserts a byte enable.
    p_narrow_no_be_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !wide_q) |-> (bhe_n && ble_n)) else $error("byte enable in 8-bit window");
    // R14: a ready block has no select low, and responses last one clock.
    p_ready_idle_r14: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&ms_n)) else $error("ready while cycle runs");
    p_rsp_pulse_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |=> !rsp_valid) else $error("response longer than one clock");

endmodule

// File: rtl/xbus_master.sv
// Top of the multiplexed external bus controller: configuration storage,
// window decoder and cycle sequencer. The shared lines are split into an
// outgoing value, a drive enable and an incoming value for the pad ring.
// Assumes one request at a time through a valid/ready handshake.
module xbus_master
    import xbus_pkg::*;
#(
    parameter int          NUM_WIN  = 4,
    parameter int          ADDR_W   = 32,
    parameter int          WIN_BITS = 17,
    parameter int          SEL_LSB  = 28,
    parameter logic [15:0] TIM_RST  = 16'h70FF,
    localparam int         CFG_AW   = $clog2(3 * NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [15:0]        cfg_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BUS_W-1:0]   req_wdata,
    input  logic [1:0]         req_be,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [BUS_W-1:0]   rsp_rdata,
    output logic [BUS_W-1:0]   ad_o,
    output logic               ad_oe,
    input  logic [BUS_W-1:0]   ad_i,
    output logic               a16,
    output logic               ae,
    output logic               rs_n,
    output logic               ws_n,
    output logic [NUM_WIN-1:0] ms_n,
    output logic               bhe_n,
    output logic               ble_n
);

    localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic                     glob_en;
    logic [NUM_WIN-1:0]       win_en, win_wide, dec_hit;
    xb_timing_t [NUM_WIN-1:0] win_tim;
    logic [IDX_W-1:0]         dec_idx;
    logic                     dec_ok;

    xbus_cfg #(.NUM_WIN(NUM_WIN), .TIM_RST(TIM_RST), .CFG_AW(CFG_AW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .glob_en   (glob_en),
        .win_en    (win_en),
        .win_wide  (win_wide),
        .win_tim   (win_tim)
    );

    xbus_win_dec #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS),
                   .SEL_LSB(SEL_LSB), .IDX_W(IDX_W)) u_dec (
        .addr_hi (req_addr[ADDR_W-1:WIN_BITS]),
        .glob_en (glob_en),
        .win_en  (win_en),
        .hit     (dec_hit),
        .hit_idx (dec_idx),
        .hit_ok  (dec_ok)
    );

    xbus_seq #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr_lo (req_addr[16:0]),
        .req_wdata   (req_wdata),
        .req_be      (req_be),
        .dec_ok      (dec_ok),
        .dec_hit     (dec_hit),
        .dec_idx     (dec_idx),
        .win_wide    (win_wide),
        .win_tim     (win_tim),
        .rsp_valid   (rsp_valid),
        .rsp_err     (rsp_err),
        .rsp_rdata   (rsp_rdata),
        .ad_o        (ad_o),
        .ad_oe       (ad_oe),
        .ad_i        (ad_i),
        .a16         (a16),
        .ae          (ae),
        .rs_n        (rs_n),
        .ws_n        (ws_n),
        .ms_n        (ms_n),
        .bhe_n       (bhe_n),
        .ble_n       (ble_n)
    );

endmodule

// File: tb/sim_xbus_master.sv
// Directed bench for xbus_master: one task per scenario, with a bus monitor
// that counts the clocks of each phase. Outputs are sampled on falling edges.
module sim_xbus_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid, rsp_err;
    logic [15:0] rsp_rdata, ad_o;
    logic        ad_oe;
    logic [15:0] ad_i = '0;
    logic        a16, ae, rs_n, ws_n, bhe_n, ble_n;
    logic [3:0]  ms_n;

    int n_cmp = 0;
    int n_bad = 0;

    // Monitor results of the last transfer.
    int          m_ae, m_ms, m_rs, m_ws, m_hold, m_turn, m_tail, m_tail_oe;
    int          m_rd_oe, m_be_cnt, m_be_idx, m_lat, m_act, m_busy_ready;
    logic [15:0] m_addr, m_wdat, m_rdata;
    logic [3:0]  m_sel;
    logic [1:0]  m_wbe;
    logic        m_a16, m_err, m_pulse_ok;

    always #4 clk = ~clk;

    xbus_master u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
        .a16(a16), .ae(ae), .rs_n(rs_n), .ws_n(ws_n), .ms_n(ms_n),
        .bhe_n(bhe_n), .ble_n(ble_n)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Run one request and record what appears on the bus until the response.
    task automatic xfer(input logic wr, input logic [31:0] a, input logic [15:0] wd,
                        input logic [1:0] be, input logic [15:0] pat, input int exp_rs);
        int  rs_seen = 0;
        bit  strobe_seen = 0;
        bit  act;
        m_ae = 0; m_ms = 0; m_rs = 0; m_ws = 0; m_hold = 0; m_turn = 0; m_tail = 0;
        m_tail_oe = 0; m_rd_oe = 0; m_be_cnt = 0; m_be_idx = 0; m_lat = 0; m_act = 0;
        m_busy_ready = 0; m_addr = '0; m_wdat = '0; m_sel = '1; m_wbe = '1; m_a16 = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
        ad_i = ~pat;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            m_lat++;
            if (rsp_valid) break;
            act = (ms_n != 4'hF);
            if (act || ae || !rs_n || !ws_n || ad_oe) m_act++;
            if (act) begin m_ms++; m_sel = ms_n; m_a16 = a16; if (req_ready) m_busy_ready++; end
            if (ae) begin m_ae++; m_addr = ad_o; end
            if (!rs_n || !ws_n) strobe_seen = 1;
            if (act && !ae && ad_oe && rs_n && ws_n && !strobe_seen) m_hold++;
            if (act && !ad_oe && rs_n && ws_n && !strobe_seen) m_turn++;
            if (act && rs_n && ws_n && strobe_seen) begin
                m_tail++;
                if (ad_oe) begin m_tail_oe++; m_wdat = ad_o; end
            end
            if (!ws_n) begin m_ws++; m_wdat = ad_o; m_wbe = {bhe_n, ble_n}; end
            if (!rs_n) begin
                m_rs++; rs_seen++;
                if (ad_oe) m_rd_oe++;
                if (!bhe_n || !ble_n) begin m_be_cnt++; m_be_idx = rs_seen; end
            end
            ad_i = (!rs_n && rs_seen == exp_rs) ? pat : ~pat;
        end
        m_err = rsp_err;
        m_rdata = rsp_rdata;
        @(negedge clk);
        m_pulse_ok = !rsp_valid;
    endtask

    task automatic t_reset;
        chk("R14", "ready after reset", req_ready, 1);
        chk("R14", "rsp_valid after reset", rsp_valid, 0);
        chk("R1", "selects after reset", ms_n, 4'hF);
        chk("R13", "drive after reset", ad_oe, 0);
        chk("R4", "ae after reset", ae, 0);
        chk("R8", "strobes after reset", {rs_n, ws_n}, 2'b11);
    endtask

    task automatic t_refused;
        // Global enable still clear (R3 reset value), window 0 disabled.
        xfer(0, 32'h1000_0000, 0, 2'b11, 16'h1111, 2);
        chk("R2", "error with all disabled", m_err, 1);
        chk("R2", "latency", m_lat, 1);
        chk("R2", "no activity", m_act, 0);
        cfg_write(4'd4, 16'h0003);
        xfer(0, 32'h1000_0000, 0, 2'b11, 16'h1111, 2);
        chk("R2", "error with global enable clear", m_err, 1);
        cfg_write(4'd0, 16'h0001);
        xfer(0, 32'h5000_0000, 0, 2'b11, 16'h1111, 2);
        chk("R2", "error above last window", m_err, 1);
        xfer(1, 32'h1002_0000, 16'h7777, 2'b11, 16'h1111, 2);
        chk("R2", "error past window end", m_err, 1);
        chk("R2", "no activity past window", m_act, 0);
        xfer(0, 32'h3000_0000, 0, 2'b11, 16'h1111, 2);
        chk("R2", "error on disabled window", m_err, 1);
        chk("R14", "error response one clock", m_pulse_ok, 1);
    endtask

    task automatic t_default_timing;
        // Window 0 enabled 16-bit, timing left at 0x70FF.
        xfer(0, 32'h1000_2468, 0, 2'b11, 16'h5A3C, 17);
        chk("R3", "no error", m_err, 0);
        chk("R3", "default address clocks", m_ae, 8);
        chk("R3", "default read strobe clocks", m_rs, 17);
        chk("R3", "default cycle clocks", m_ms, 25);
        chk("R1", "select window 0", m_sel, 4'b1110);
        chk("R12", "word address", m_addr, 16'h1234);
        chk("R12", "a16 low", m_a16, 0);
        chk("R7", "read data", m_rdata, 16'h5A3C);
        chk("R10", "enable clocks", m_be_cnt, 1);
        chk("R10", "enable in last strobe clock", m_be_idx, 17);
        chk("R13", "no drive in strobe", m_rd_oe, 0);
        chk("R14", "not ready while busy", m_busy_ready, 0);
        chk("R14", "response one clock", m_pulse_ok, 1);
    endtask

    task automatic t_fast;
        cfg_write(4'd5, 16'h0003);
        cfg_write(4'd9, 16'h0000);
        xfer(0, 32'h2000_0010, 0, 2'b11, 16'h1357, 2);
        chk("R4", "min address clocks", m_ae, 1);
        chk("R7", "min read strobe", m_rs, 2);
        chk("R7", "min cycle", m_ms, 3);
        chk("R7", "fast read data", m_rdata, 16'h1357);
        chk("R10", "fast enable position", m_be_idx, 2);
        chk("R1", "select window 1", m_sel, 4'b1101);
        xfer(1, 32'h2000_0020, 16'hC0DE, 2'b01, 0, 2);
        chk("R8", "min write strobe", m_ws, 2);
        chk("R8", "write data", m_wdat, 16'hC0DE);
        chk("R8", "low lane only", m_wbe, 2'b10);
        chk("R4", "write address", m_addr, 16'h0010);
    endtask

    task automatic t_hold_turn;
        cfg_write(4'd7, 16'h0003);
        cfg_write(4'd11, 16'h2603);
        xfer(0, 32'h4001_0002, 0, 2'b11, 16'h0F0F, 5);
        chk("R4", "extended address clocks", m_ae, 3);
        chk("R5", "hold clocks", m_hold, 1);
        chk("R6", "turnaround clocks", m_turn, 1);
        chk("R7", "stretched read strobe", m_rs, 5);
        chk("R7", "cycle clocks", m_ms, 10);
        chk("R7", "read data", m_rdata, 16'h0F0F);
        chk("R12", "address bits 16:1", m_addr, 16'h8001);
        chk("R1", "select window 3", m_sel, 4'b0111);
    endtask

    task automatic t_tail;
        cfg_write(4'd11, 16'h0350);
        xfer(1, 32'h4000_0100, 16'hBEEF, 2'b11, 0, 2);
        chk("R6", "no turnaround on write", m_turn, 0);
        chk("R8", "stretched write strobe", m_ws, 7);
        chk("R9", "write tail clocks", m_tail, 1);
        chk("R9", "write tail driven", m_tail_oe, 1);
        chk("R9", "write tail data", m_wdat, 16'hBEEF);
        chk("R8", "both lanes", m_wbe, 2'b00);
        chk("R9", "write cycle clocks", m_ms, 9);
        cfg_write(4'd9, 16'h0100);
        xfer(0, 32'h2000_0000, 0, 2'b11, 16'h2468, 2);
        chk("R9", "read tail clocks", m_tail, 1);
        chk("R13", "read tail released", m_tail_oe, 0);
        chk("R9", "read tail cycle", m_ms, 4);
    endtask

    task automatic t_narrow;
        cfg_write(4'd6, 16'h0001);
        cfg_write(4'd10, 16'h0001);
        xfer(0, 32'h3001_2345, 0, 2'b11, 16'h9966, 3);
        chk("R11", "a16 carries bit 16", m_a16, 1);
        chk("R11", "byte address", m_addr, 16'h2345);
        chk("R11", "no enables", m_be_cnt, 0);
        chk("R11", "low byte read", m_rdata, 16'h0066);
        chk("R1", "select window 2", m_sel, 4'b1011);
        xfer(1, 32'h3000_00FF, 16'hABCD, 2'b11, 0, 2);
        chk("R11", "low byte written", m_wdat, 16'h00CD);
        chk("R11", "no write enables", m_wbe, 2'b11);
        chk("R11", "a16 clear", m_a16, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_refused();
        t_default_timing();
        t_fast();
        t_hold_turn();
        t_tail();
        t_narrow();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule